// File: doc/BRIEF.md
# Bank Machine Crossbar

This block connects several memory masters to several bank machines in a split-transaction memory system. A master opens a request by raising its strobe with a valid address and write-enable. The crossbar reads the bank-select bits of that address, arbitrates among all masters that target the same bank machine, and forwards the winner's command. Command acknowledgements and data acknowledgements from each bank machine are steered back to the master that holds that bank.

A bank machine that has accepted more commands than it has answered with data acknowledgements raises its lock input. While lock is high, the grant on that bank cannot move. The data acknowledgements that the bank still owes therefore reach the master that issued the commands, and each master sees its own transactions complete in order. Write data is not multiplexed. Every master drives zero outside its write window, and the crossbar ORs all master write buses into a single bus.

Each bank machine has its own round-robin arbiter, so different banks can serve different masters in the same cycle. The number of masters, the number of bank machines, the address and data widths and the position of the bank field are parameters.

Top module: `bank_xbar`

## Requirements
- R1: A strobing master whose address bits [BANK_LSB+log2(N_BANKS)-1 : BANK_LSB] equal k is presented on `b_stb[k]` and on no other bank strobe, and only while it holds bank k.
- R2: `b_addr` and `b_we` of a bank carry the address and write-enable of the master holding that bank whenever `b_stb` of that bank is high.
- R3: A command acknowledgement from bank k reaches only the master that holds bank k and is strobing it in that cycle.
- R4: When bank k is unlocked and not held by a continuing request, it is granted in the same cycle to the first requesting master after the last grantee, counting upward with wrap-around.
- R5: A master that was forwarded to bank k in the previous cycle and still strobes bank k keeps it, even if other masters request bank k.
- R6: While bank k's lock is high, its grant does not change, and no other master's request reaches `b_stb[k]`, even if the holder is idle.
- R7: A master whose target bank is held by another master gets no command acknowledgement, even when that bank raises its acknowledgement.
- R8: A data acknowledgement from bank k is delivered to the master currently holding bank k, to no other master.
- R9: `b_wdata` is the bitwise OR of all master write-data buses.
- R10: After reset no bank is held, the last grantee of every bank is master N_MASTERS-1, so the first arbitration favours master 0, and with idle inputs all outputs are zero.
- R11: Bank machines arbitrate independently, so in one cycle different banks can forward and acknowledge different masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| m_stb | input | N_MASTERS | Request strobe per master |
| m_we | input | N_MASTERS | Write-enable per master |
| m_addr | input | N_MASTERS*ADDR_W | Address per master, master 0 in the low slice |
| m_wdata | input | N_MASTERS*DATA_W | Write data per master, zero when not writing |
| m_req_ack | output | N_MASTERS | Command acknowledgement per master |
| m_dat_ack | output | N_MASTERS | Data acknowledgement per master |
| b_stb | output | N_BANKS | Request strobe per bank machine |
| b_we | output | N_BANKS | Write-enable per bank machine |
| b_addr | output | N_BANKS*ADDR_W | Address per bank machine, bank 0 in the low slice |
| b_req_ack | input | N_BANKS | Command acknowledgement from each bank machine |
| b_dat_ack | input | N_BANKS | Data acknowledgement from each bank machine |
| b_lock | input | N_BANKS | Outstanding-data lock from each bank machine |
| b_wdata | output | DATA_W | OR of all master write data |

## Verification
A wrong grant register shows up in the same cycle as a command forwarded from the wrong master on `b_addr` and `b_we`, or as an acknowledgement on the wrong `m_req_ack` bit. A grant that moves while lock is high shows up later, when the owed data acknowledgement reaches a master that never issued the command. The data acknowledgements are placed several cycles after the lock appears, with a competing master waiting, so that this delayed symptom cannot be missed. A bad arbiter pointer only shows when two masters contend after a release, and the stimulus creates that contention after each hand-over.

// File: rtl/bank_xbar_pkg.sv
package bank_xbar_pkg;

  // Index width for selecting one of n items; never zero.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bank_xbar_decode.sv
module bank_xbar_decode #(
  parameter int ADDR_W   = 24,
  parameter int N_BANKS  = 4,
  parameter int BANK_LSB = 2
) (
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_BANKS-1:0] target
);
  import bank_xbar_pkg::*;
  localparam int BW = idx_w(N_BANKS);

  function automatic logic [BW-1:0] bank_field(input logic [ADDR_W-1:0] a);
    return a[BANK_LSB +: BW];
  endfunction

  always_comb begin
    target = '0;
    if (stb) target[bank_field(addr)] = 1'b1;
  end
endmodule

// File: rtl/bank_xbar_arb.sv
module bank_xbar_arb #(
  parameter int N_MASTERS = 2,
  parameter int MW        = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 lock,
  output logic [MW-1:0]        grant
);
  logic [MW-1:0] owner_q;
  logic          active_q;
  logic          hold;
  logic [MW-1:0] pick;

  // First requester after 'last', wrapping; 'last' itself is tried last.
  function automatic logic [MW-1:0] rr_pick(input logic [N_MASTERS-1:0] r,
                                            input logic [MW-1:0] last);
    logic [MW-1:0] res;
    logic found;
    res   = last;
    found = 1'b0;
    for (int i = 1; i <= N_MASTERS; i++) begin
      int idx;
      idx = (int'(last) + i) % N_MASTERS;
      if (!found && r[idx]) begin
        res   = MW'(idx);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  assign hold  = lock | (active_q & req[owner_q]);
  assign pick  = rr_pick(req, owner_q);
  assign grant = hold ? owner_q : pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= MW'(N_MASTERS - 1);
      active_q <= 1'b0;
    end else begin
      owner_q  <= grant;
      active_q <= req[grant];
    end
  end
endmodule

// File: rtl/bank_xbar_wmerge.sv
module bank_xbar_wmerge #(
  parameter int N_MASTERS = 2,
  parameter int DATA_W    = 32
) (
  input  logic [N_MASTERS*DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0]           wdata_out
);
  always_comb begin
    wdata_out = '0;
    for (int m = 0; m < N_MASTERS; m++)
      wdata_out = wdata_out | wdata_in[m*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/bank_xbar.sv
module bank_xbar #(
  parameter int N_MASTERS = 2,
  parameter int N_BANKS   = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int BANK_LSB  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_MASTERS-1:0]          m_stb,
  input  logic [N_MASTERS-1:0]          m_we,
  input  logic [N_MASTERS*ADDR_W-1:0]   m_addr,
  input  logic [N_MASTERS*DATA_W-1:0]   m_wdata,
  output logic [N_MASTERS-1:0]          m_req_ack,
  output logic [N_MASTERS-1:0]          m_dat_ack,
  output logic [N_BANKS-1:0]            b_stb,
  output logic [N_BANKS-1:0]            b_we,
  output logic [N_BANKS*ADDR_W-1:0]     b_addr,
  input  logic [N_BANKS-1:0]            b_req_ack,
  input  logic [N_BANKS-1:0]            b_dat_ack,
  input  logic [N_BANKS-1:0]            b_lock,
  output logic [DATA_W-1:0]             b_wdata
);
  import bank_xbar_pkg::*;
  localparam int MW = idx_w(N_MASTERS);

  logic [N_BANKS-1:0]   target   [N_MASTERS];
  logic [N_MASTERS-1:0] bank_req [N_BANKS];
  logic [MW-1:0]        grant    [N_BANKS];
  logic [N_BANKS*MW-1:0] grant_flat;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_dec
    bank_xbar_decode #(.ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .BANK_LSB(BANK_LSB)) u_dec (
      .stb    (m_stb[m]),
      .addr   (m_addr[m*ADDR_W +: ADDR_W]),
      .target (target[m])
    );
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    for (genvar m = 0; m < N_MASTERS; m++) begin : g_req
      assign bank_req[b][m] = target[m][b];
    end
    bank_xbar_arb #(.N_MASTERS(N_MASTERS), .MW(MW)) u_arb (
      .clk   (clk),
      .rst   (rst),
      .req   (bank_req[b]),
      .lock  (b_lock[b]),
      .grant (grant[b])
    );
    assign grant_flat[b*MW +: MW] = grant[b];
  end

  // Forward path: each bank shows its holder's command.
  always_comb begin
    for (int b = 0; b < N_BANKS; b++) begin
      b_stb[b]                  = bank_req[b][grant[b]];
      b_we[b]                   = m_we[grant[b]];
      b_addr[b*ADDR_W +: ADDR_W] = m_addr[int'(grant[b])*ADDR_W +: ADDR_W];
    end
  end

  // Return path: acknowledgements steered to each bank's holder.
  always_comb begin
    m_req_ack = '0;
    m_dat_ack = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      for (int m = 0; m < N_MASTERS; m++) begin
        if (int'(grant[b]) == m) begin
          m_req_ack[m] = m_req_ack[m] | (b_req_ack[b] & b_stb[b]);
          m_dat_ack[m] = m_dat_ack[m] | b_dat_ack[b];
        end
      end
    end
  end

  bank_xbar_wmerge #(.N_MASTERS(N_MASTERS), .DATA_W(DATA_W)) u_wmerge (
    .wdata_in  (m_wdata),
    .wdata_out (b_wdata)
  );
endmodule

// File: rtl/bank_xbar_chk.sv
module bank_xbar_chk #(
  parameter int N_MASTERS = 2,
  parameter int N_BANKS   = 4,
  parameter int ADDR_W    = 24,
  parameter int BANK_LSB  = 2,
  parameter int MW        = 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_MASTERS-1:0]      m_stb,
  input logic [N_MASTERS-1:0]      m_req_ack,
  input logic [N_MASTERS-1:0]      m_dat_ack,
  input logic [N_BANKS-1:0]        b_stb,
  input logic [N_BANKS*ADDR_W-1:0] b_addr,
  input logic [N_BANKS-1:0]        b_dat_ack,
  input logic [N_BANKS-1:0]        b_lock,
  input logic [N_BANKS*MW-1:0]     grant_flat
);
  import bank_xbar_pkg::*;
  localparam int BW = idx_w(N_BANKS);

  for (genvar k = 0; k < N_BANKS; k++) begin : g_b
    // R1
    bank_route_chk: assert property (@(posedge clk) disable iff (rst)
      b_stb[k] |-> (b_addr[k*ADDR_W + BANK_LSB +: BW] == BW'(k)));

    // R2
    holder_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      b_stb[k] |-> m_stb[grant_flat[k*MW +: MW]]);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (b_lock[k] && $past(b_lock[k])) |-> $stable(grant_flat[k*MW +: MW]));
  end

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_m
    // R3
    ack_to_strober_chk: assert property (@(posedge clk) disable iff (rst)
      m_req_ack[m] |-> m_stb[m]);
  end

  // R8
  dat_ack_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(m_dat_ack) <= $countones(b_dat_ack));
endmodule

bind bank_xbar bank_xbar_chk #(
  .N_MASTERS (N_MASTERS),
  .N_BANKS   (N_BANKS),
  .ADDR_W    (ADDR_W),
  .BANK_LSB  (BANK_LSB),
  .MW        (MW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .m_stb      (m_stb),
  .m_req_ack  (m_req_ack),
  .m_dat_ack  (m_dat_ack),
  .b_stb      (b_stb),
  .b_addr     (b_addr),
  .b_dat_ack  (b_dat_ack),
  .b_lock     (b_lock),
  .grant_flat (grant_flat)
);

// File: tb/bank_xbar_test.sv
`timescale 1ns/1ps
module bank_xbar_test;
  localparam int NM = 2, NB = 4, AW = 8, DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NM-1:0]    m_stb = '0, m_we = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0;
  logic [NM-1:0]    m_req_ack, m_dat_ack;
  logic [NB-1:0]    b_stb, b_we;
  logic [NB*AW-1:0] b_addr;
  logic [NB-1:0]    b_req_ack = '0, b_dat_ack = '0, b_lock = '0;
  logic [DW-1:0]    b_wdata;

  bank_xbar #(.N_MASTERS(NM), .N_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .BANK_LSB(2)) uut (
    .clk(clk), .rst(rst), .m_stb(m_stb), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_req_ack(m_req_ack), .m_dat_ack(m_dat_ack), .b_stb(b_stb), .b_we(b_we), .b_addr(b_addr),
    .b_req_ack(b_req_ack), .b_dat_ack(b_dat_ack), .b_lock(b_lock), .b_wdata(b_wdata));

  typedef struct packed {
    logic [1:0] stb, we;
    logic [7:0] a0, a1, w0, w1;
    logic [3:0] rack, dack, lock;
    logic [3:0] e_bstb, e_src;
    logic [1:0] e_rack, e_dack;
    logic [7:0] e_wor;
  } vec_t;

  // Bank field is address bits [3:2]; e_src bit k names the master expected on bank k.
  localparam vec_t TBL [15] = '{
    '{2'b00,2'b00,8'h00,8'h00,8'h00,8'h00,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,2'b00,2'b00,8'h00}, // idle
    '{2'b11,2'b01,8'h10,8'h80,8'h00,8'h00,4'b0001,4'b0000,4'b0000,4'b0001,4'b0000,2'b01,2'b00,8'h00}, // R4 R10
    '{2'b10,2'b01,8'h10,8'h80,8'h00,8'h00,4'b0001,4'b0000,4'b0001,4'b0000,4'b0000,2'b00,2'b00,8'h00}, // R6 R7
    '{2'b10,2'b01,8'h00,8'h80,8'h5A,8'h00,4'b0000,4'b0001,4'b0001,4'b0000,4'b0000,2'b00,2'b01,8'h5A}, // R8
    '{2'b10,2'b11,8'h00,8'h80,8'h00,8'h00,4'b0001,4'b0000,4'b0000,4'b0001,4'b0001,2'b10,2'b00,8'h00}, // R4
    '{2'b11,2'b11,8'h10,8'h90,8'h00,8'h00,4'b0001,4'b0000,4'b0001,4'b0001,4'b0001,2'b10,2'b00,8'h00}, // R6 pipelined
    '{2'b01,2'b00,8'h10,8'h00,8'h00,8'hA5,4'b0000,4'b0001,4'b0001,4'b0000,4'b0000,2'b00,2'b10,8'hA5}, // R8
    '{2'b01,2'b00,8'h10,8'h00,8'h00,8'h0F,4'b0000,4'b0001,4'b0001,4'b0000,4'b0000,2'b00,2'b10,8'h0F}, // R8
    '{2'b01,2'b01,8'h10,8'h00,8'h00,8'h00,4'b0000,4'b0000,4'b0000,4'b0001,4'b0000,2'b00,2'b00,8'h00}, // R4
    '{2'b11,2'b01,8'h10,8'h80,8'h30,8'h03,4'b0001,4'b0000,4'b0000,4'b0001,4'b0000,2'b01,2'b00,8'h33}, // R5 R9
    '{2'b11,2'b00,8'h38,8'h80,8'h00,8'h00,4'b0101,4'b0000,4'b0001,4'b0100,4'b0000,2'b01,2'b00,8'h00}, // R11 R7
    '{2'b11,2'b00,8'h4C,8'h94,8'h00,8'h00,4'b1010,4'b0101,4'b0101,4'b1010,4'b0010,2'b11,2'b01,8'h00}, // R11
    '{2'b10,2'b00,8'h00,8'hBC,8'h00,8'h00,4'b1000,4'b1010,4'b1010,4'b0000,4'b0000,2'b00,2'b11,8'h00}, // R6 R8
    '{2'b10,2'b00,8'h00,8'hBC,8'h00,8'h00,4'b1000,4'b0000,4'b0000,4'b1000,4'b1000,2'b10,2'b00,8'h00}, // R4
    '{2'b00,2'b00,8'h00,8'h00,8'h00,8'h00,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,2'b00,2'b00,8'h00}
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    m_stb = v.stb; m_we = v.we;
    m_addr = {v.a1, v.a0}; m_wdata = {v.w1, v.w0};
    b_req_ack = v.rack; b_dat_ack = v.dack; b_lock = v.lock;
  endtask

  task automatic check_row(input vec_t v);
    chk("R1 bank strobes", 32'(b_stb), 32'(v.e_bstb));
    chk("R3/R7 command ack", 32'(m_req_ack), 32'(v.e_rack));
    chk("R8 data ack", 32'(m_dat_ack), 32'(v.e_dack));
    chk("R9 merged write data", 32'(b_wdata), 32'(v.e_wor));
    for (int k = 0; k < NB; k++) begin
      if (v.e_bstb[k]) begin
        chk("R2 forwarded address", 32'(b_addr[k*AW +: AW]), 32'(v.e_src[k] ? v.a1 : v.a0));
        chk("R2 forwarded write-enable", 32'(b_we[k]), 32'(v.we[v.e_src[k]]));
      end
    end
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: idle outputs in reset
    chk("R10 reset strobes", 32'(b_stb), 32'h0);
    chk("R10 reset acks", 32'({m_req_ack, m_dat_ack}), 32'h0);
    @(posedge clk); #1 rst = 1'b0;

    for (int i = 0; i < 15; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      check_row(TBL[i]);
      @(posedge clk); #1;
    end

    // R10: reset after activity restores master 0 preference on bank 1
    rst = 1'b1;
    m_stb = 2'b11; m_we = 2'b10; m_addr = {8'h94, 8'h14};
    @(posedge clk); #1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R10 first grant after reset", 32'(b_addr[1*AW +: AW]), 32'h14);
    chk("R10 strobe on bank 1", 32'(b_stb), 32'b0010);
    @(posedge clk); #1;
    // R4: holder drops, waiting master takes bank 1 immediately
    m_stb = 2'b10;
    b_req_ack = 4'b0010;
    @(negedge clk);
    chk("R4 hand-over address", 32'(b_addr[1*AW +: AW]), 32'h94);
    chk("R4 hand-over write-enable", 32'(b_we[1]), 32'h1);
    chk("R3 ack to new holder", 32'(m_req_ack), 32'b10);
    @(posedge clk); #1;
    m_stb = '0; b_req_ack = '0;
    @(negedge clk);
    chk("R10 idle after run", 32'(b_stb), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule